// File: doc/BRIEF.md
# Regulator Over-drive Switching Sequencer

This block sequences a core voltage regulator between its Normal and Over-drive modes through a two-bit control word. Software sets an enable bit to start a preparation phase. After a fixed settle delay the block raises a ready flag. Only then does a switch bit take effect. Setting the switch bit starts the transition to Over-drive. The block holds a system-stall output for the whole transition and raises a switch-ready flag when it completes.

There are two ways back to Normal. Clearing only the switch bit keeps over-drive enabled but inactive. Clearing the enable bit, alone or together with the switch bit, disables over-drive completely and clears the switch bit in hardware. A stop-mode exit pulse resets the whole handshake. Control writes are honoured only while the system clock runs from a plain oscillator, not from the PLL. Both settle delays are counted in clock cycles and set by parameters.

Top module: `od_sequencer`

## Requirements
- R1: Accepting a write with the enable bit (write data bit 0) set while disabled sets the enable flag (read bit 0) at that edge. The ready flag (read bit 2) rises exactly PREP_CYCLES clock edges later. If enable is cleared during preparation, ready never rises.
- R2: A write with the switch bit (write data bit 1) set takes effect only if, at the accepting edge, both the enable flag and the ready flag are already set and enable is written 1. In every other case the switch flag (read bit 1) is left unchanged.
- R3: An accepted switch-up sets the switch flag and raises stall_o at the same edge. stall_o stays high for exactly SW_CYCLES cycles. The switch-ready flag (read bit 3) rises on the edge where stall_o falls.
- R4: A write of enable=1, switch=0 while the switch flag is set clears the switch flag and stalls for SW_CYCLES cycles. The switch-ready flag clears when the stall ends. The enable and ready flags stay set.
- R5: A write with enable=0 clears the enable, ready and switch flags at the accepting edge, whatever the switch bit holds. If over-drive was active, stall_o is high for SW_CYCLES cycles and the switch-ready flag then clears. Otherwise no stall occurs.
- R6: A stop_exit_i pulse clears all four flags and stall_o at the next edge and aborts any pending delay. It has priority over a write in the same cycle.
- R7: A write presented while clk_pll_i is high has no effect on any flag.
- R8: A write presented while stall_o is high has no effect on any flag.
- R9: After reset, rdata_o is 0 and stall_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Control write strobe |
| wdata_i | input | 2 | Write data: bit 0 enable, bit 1 switch |
| clk_pll_i | input | 1 | High while the system clock is sourced from the PLL |
| stop_exit_i | input | 1 | One-cycle pulse on exit from Stop mode |
| rdata_o | output | 4 | Status: bit 0 enable, bit 1 switch, bit 2 ready, bit 3 switch-ready |
| stall_o | output | 1 | System stall, high during a regulator switch |

## Verification
The bench builds the block with PREP_CYCLES=3 and SW_CYCLES=4. At these values every settle window lasts only a handful of cycles, so exact edge counts can be measured directly. They also make an exhaustive sweep affordable. The sweep covers the three stable regulator states, crossed with all four write-data values and both clock-source settings, and compares the final flags and the number of stall cycles against values derived from the requirements. Directed runs cover the narrower cases: a switch requested before ready, a write during a stall, a stop exit in the middle of a switch, and preparation aborted early.

// File: rtl/od_seq_pkg.sv
`timescale 1ns/1ps
package od_seq_pkg;
  localparam int WR_EN_BIT = 0;
  localparam int WR_SW_BIT = 1;

  typedef struct packed {
    logic sw_rdy;
    logic rdy;
    logic sw;
    logic en;
  } od_stat_t;
endpackage

// File: rtl/od_delay_cnt.sv
`timescale 1ns/1ps
module od_delay_cnt #(
  parameter int DELAY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CW'(DELAY);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(1)) && !abort_i;
endmodule

// File: rtl/od_ctrl.sv
`timescale 1ns/1ps
module od_ctrl
  import od_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       clk_pll_i,
  input  logic       stop_exit_i,
  input  logic       prep_done_i,
  input  logic       sw_done_i,
  input  logic       sw_busy_i,
  output logic       prep_start_o,
  output logic       prep_abort_o,
  output logic       sw_start_o,
  output logic       sw_abort_o,
  output od_stat_t   stat_o
);
  od_stat_t st_q, st_d;
  logic     wr_ok, want_en, want_sw;

  assign wr_ok   = wr_i && !clk_pll_i && !sw_busy_i && !stop_exit_i;
  assign want_en = wdata_i[WR_EN_BIT];
  assign want_sw = wdata_i[WR_SW_BIT];

  always_comb begin
    st_d         = st_q;
    prep_start_o = 1'b0;
    prep_abort_o = 1'b0;
    sw_start_o   = 1'b0;
    sw_abort_o   = 1'b0;
    if (stop_exit_i) begin
      st_d         = '0;
      prep_abort_o = 1'b1;
      sw_abort_o   = 1'b1;
    end else begin
      if (prep_done_i) st_d.rdy = 1'b1;
      if (sw_done_i)   st_d.sw_rdy = st_q.sw;
      if (wr_ok) begin
        if (!want_en) begin
          // disable: hardware drops the switch bit, step back if active
          st_d.en      = 1'b0;
          st_d.rdy     = 1'b0;
          st_d.sw      = 1'b0;
          prep_abort_o = 1'b1;
          sw_start_o   = st_q.sw;
        end else if (!st_q.en) begin
          st_d.en      = 1'b1;
          prep_start_o = 1'b1;
        end else if (want_sw && !st_q.sw && st_q.rdy) begin
          st_d.sw    = 1'b1;
          sw_start_o = 1'b1;
        end else if (!want_sw && st_q.sw) begin
          st_d.sw    = 1'b0;
          sw_start_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign stat_o = st_q;
endmodule

// File: rtl/od_sequencer.sv
`timescale 1ns/1ps
module od_sequencer
  import od_seq_pkg::*;
#(
  parameter int PREP_CYCLES = 3,
  parameter int SW_CYCLES   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       clk_pll_i,
  input  logic       stop_exit_i,
  output logic [3:0] rdata_o,
  output logic       stall_o
);
  logic     prep_start, prep_abort, prep_done, prep_busy;
  logic     sw_start, sw_abort, sw_done, sw_busy;
  od_stat_t stat;

  od_delay_cnt #(.DELAY(PREP_CYCLES)) u_prep_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prep_start),
    .abort_i (prep_abort),
    .busy_o  (prep_busy),
    .done_o  (prep_done)
  );

  od_delay_cnt #(.DELAY(SW_CYCLES)) u_sw_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sw_start),
    .abort_i (sw_abort),
    .busy_o  (sw_busy),
    .done_o  (sw_done)
  );

  od_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .wdata_i      (wdata_i),
    .clk_pll_i    (clk_pll_i),
    .stop_exit_i  (stop_exit_i),
    .prep_done_i  (prep_done),
    .sw_done_i    (sw_done),
    .sw_busy_i    (sw_busy),
    .prep_start_o (prep_start),
    .prep_abort_o (prep_abort),
    .sw_start_o   (sw_start),
    .sw_abort_o   (sw_abort),
    .stat_o       (stat)
  );

  logic unused_prep_busy;
  assign unused_prep_busy = prep_busy;

  assign rdata_o = stat;
  assign stall_o = sw_busy;
endmodule

// File: rtl/od_seq_chk.sv
`timescale 1ns/1ps
module od_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [1:0] wdata_i,
  input logic       clk_pll_i,
  input logic       stop_exit_i,
  input logic [3:0] rdata_o,
  input logic       stall_o
);
  logic unused_in;
  assign unused_in = wr_i ^ wdata_i[0] ^ wdata_i[1];

  p_rdy_needs_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[2] |-> rdata_o[0]);

  p_sw_needs_rdy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[1]) |-> $past(rdata_o[2]) && $past(rdata_o[0]));

  p_stall_on_switch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[1]) |-> stall_o);

  p_swrdy_at_stall_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stall_o) && !$past(stop_exit_i)) |-> (rdata_o[3] != $past(rdata_o[3])));

  p_stop_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_exit_i |=> (rdata_o == 4'b0000) && !stall_o);

  p_pll_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_pll_i && !stop_exit_i) |=> $stable(rdata_o[1:0]));

  p_stall_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !stop_exit_i) |=> $stable(rdata_o[1:0]));
endmodule

bind od_sequencer od_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .clk_pll_i   (clk_pll_i),
  .stop_exit_i (stop_exit_i),
  .rdata_o     (rdata_o),
  .stall_o     (stall_o)
);

// File: tb/od_sequencer_tb.sv
`timescale 1ns/1ps
module od_sequencer_tb;
  localparam int PREP = 3;
  localparam int SW   = 4;
  localparam int WIN  = PREP + SW + 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic       pll = 1'b0;
  logic       stop = 1'b0;
  logic [3:0] rdata;
  logic       stall;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  od_sequencer #(.PREP_CYCLES(PREP), .SW_CYCLES(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata),
    .clk_pll_i(pll), .stop_exit_i(stop), .rdata_o(rdata), .stall_o(stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_op(input logic [1:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  // 0: off, 1: enabled and ready, 2: over-drive active
  task automatic goto_state(input int s);
    stop_pulse();
    if (s >= 1) begin wr_op(2'b01); repeat (PREP + 1) @(negedge clk); end
    if (s == 2) begin wr_op(2'b11); repeat (SW + 1) @(negedge clk); end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n, hi;
    repeat (3) @(negedge clk);
    chk("R9 rdata after reset", int'(rdata), 0);
    chk("R9 stall after reset", int'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 prep delay
    wr_op(2'b01);
    chk("R1 en set at accept", int'(rdata[0]), 1);
    n = 0;
    while (!rdata[2] && n < 50) begin @(negedge clk); n++; end
    chk("R1 ready delay", n, PREP);

    // R3 switch-up timing
    wr_op(2'b11);
    chk("R3 sw set", int'(rdata[1]), 1);
    chk("R3 stall raised", int'(stall), 1);
    n = 0; hi = 0;
    while (!rdata[3] && n < 50) begin
      if (stall) hi++;
      @(negedge clk); n++;
    end
    chk("R3 switch-ready delay", n, SW);
    chk("R3 stall cycles", hi, SW);
    chk("R3 stall low with switch-ready", int'(stall), 0);

    // R2 switch before ready ignored
    goto_state(0);
    wr_op(2'b01);
    wr_op(2'b11);
    repeat (PREP + SW + 2) @(negedge clk);
    chk("R2 sw ignored before ready", int'(rdata[1]), 0);
    chk("R2 ready still reached", int'(rdata[2]), 1);

    // R8 write during stall ignored
    wr_op(2'b11);
    wr_op(2'b00);
    repeat (SW + 2) @(negedge clk);
    chk("R8 write in stall ignored", int'(rdata), 4'hF);

    // R6 stop exit during switch
    goto_state(1);
    wr_op(2'b11);
    stop_pulse();
    chk("R6 stop clears flags", int'(rdata), 0);
    chk("R6 stop clears stall", int'(stall), 0);
    repeat (SW + 2) @(negedge clk);
    chk("R6 no late switch-ready", int'(rdata), 0);

    // R6 stop has priority over write
    @(negedge clk); stop = 1'b1; wr = 1'b1; wdata = 2'b01;
    @(negedge clk); stop = 1'b0; wr = 1'b0;
    repeat (PREP + 2) @(negedge clk);
    chk("R6 stop beats write", int'(rdata), 0);

    // R5 abort preparation
    wr_op(2'b01);
    wr_op(2'b00);
    repeat (PREP + 2) @(negedge clk);
    chk("R5 prep aborted", int'(rdata), 0);

    // Sweep: state x write data x clock source
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 4; d++) begin
        for (int p = 0; p < 2; p++) begin
          int exp_rd, exp_st, cnt;
          string tag;
          goto_state(s);
          exp_rd = (s == 0) ? 0 : (s == 1) ? 4'b0101 : 4'b1111;
          exp_st = 0;
          if (p == 0) begin
            if ((d & 1) == 0) begin
              exp_rd = 0;
              exp_st = (s == 2) ? SW : 0;
            end else if (s == 0) begin
              exp_rd = 4'b0101;
            end else if (s == 1 && d == 3) begin
              exp_rd = 4'b1111; exp_st = SW;
            end else if (s == 2 && d == 1) begin
              exp_rd = 4'b0101; exp_st = SW;
            end
          end
          pll = p[0];
          wr_op(d[1:0]);
          cnt = 0;
          for (int i = 0; i < WIN; i++) begin
            if (stall) cnt++;
            @(negedge clk);
          end
          pll = 1'b0;
          tag = (p == 1) ? "R7" : ((d & 1) == 0) ? "R5" : (s == 2) ? "R4" : (s == 1) ? "R2" : "R1";
          chk($sformatf("%s sweep s%0d d%0d p%0d flags", tag, s, d, p), int'(rdata), exp_rd);
          chk($sformatf("%s sweep s%0d d%0d p%0d stall", tag, s, d, p), cnt, exp_st);
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule